// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block watches over application software. A counter advances either on every bus clock cycle or only on cycles where a slow low-power tick enable is high. If software does not service the counter before the selected timeout, the block raises a one-cycle reset request. To service it, software writes the key byte 0x55 and then the key byte 0xAA to the service address. Any other byte written there is treated as a runaway program and raises a reset request at once. An optional window, available only on the bus clock, also punishes service writes that arrive too early.

Two option registers set the timeout and the clock source. Each one accepts only its first write after reset, and that write restarts the counter. Debug and stop inputs freeze the counter on the bus clock source and clear it on the slow tick source. Two sticky cause flags record whether the most recent request came from expiry or from a bad service write. They survive the system reset and are cleared only by power-on reset.

Register writes use a 2-bit address. Address 0 is the service address. Address 1 is the timeout option, with bits [1:0] as the select. Address 2 is the source option: bit 0 = 1 selects the slow tick and 0 selects the bus clock, and bit 1 = 1 requests windowing.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the watchdog is enabled with the slow tick source, windowing off, and timeout select 2'b11 (2^LP_SH2 ticks). rst_req and both cause flags are low after power-on reset.
- R2: rst_req is high for exactly one cycle. It rises on the cycle after the counter completes its limit of advances since the last restart, and cause_timeout is then 1 and cause_badkey is 0.
- R3: With the watchdog enabled, a write to address 0 of any byte other than 0x55 or 0xAA makes rst_req high on the next cycle, with cause_badkey = 1 and cause_timeout = 0.
- R4: Only a write of 0xAA to address 0 while a 0x55 is pending restarts the counter. Further 0x55 writes keep the 0x55 pending. A 0xAA write with no 0x55 pending has no effect.
- R5: The timeout select (address 1, bits [1:0]) picks 00 = off, 01, 10 or 11 = limits of 2^SH0, 2^SH1 or 2^SH2. The BUS_SH parameters apply with the bus source and the LP_SH parameters apply with the slow source.
- R6: With the bus source and window bit (address 2, bit 1) set, any service write made while the count is below three quarters of the limit gives a bad-write reset request. A write at three quarters or later is accepted.
- R7: With the slow source, the window bit is ignored and service writes are never early.
- R8: Each option register takes only its first write after reset, and that write restarts the counter. Later writes change neither the options nor the count.
- R9: With the bus source, the counter holds while dbg_mode or stop_mode is high. With the slow source, the counter is cleared while either is high and counts from zero afterwards.
- R10: With the slow source, the counter advances only on cycles with tick_en high.
- R11: The cause flags keep their value through rst and through legal service writes. They change only when a reset request is raised and are cleared by por.
- R12: With timeout select 00, no reset request is raised and service writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high; keeps cause flags |
| por | input | 1 | Synchronous power-on reset, active high; clears everything |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 service, 1 timeout option, 2 source option |
| wr_data | input | 8 | Write data byte |
| tick_en | input | 1 | Slow low-power tick enable |
| dbg_mode | input | 1 | Debug mode active |
| stop_mode | input | 1 | Stop mode active |
| rst_req | output | 1 | One-cycle reset request |
| cause_timeout | output | 1 | Last request came from expiry (sticky) |
| cause_badkey | output | 1 | Last request came from a bad or early service write (sticky) |

## Verification
The bench drives inputs on falling edges, so each write is sampled at exactly one rising edge. That edge restarts, locks or flags state, and rst_req from a bad write is visible at the very next falling edge. Expiry is counted in falling edges from the edge that last restarted the counter. With a limit of L, rst_req must stay low for L-1 falling edges, be high at the L-th and low again at the next. Window boundaries are hit by placing the write edge at count three quarters of L minus one and at three quarters of L. Low-power cases shift the expected expiry by the held cycles or restart it from zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [1:0] A_SVC = 2'd0;
  localparam logic [1:0] A_TMO = 2'd1;
  localparam logic [1:0] A_SRC = 2'd2;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef struct packed {
    logic [1:0] tsel;   // 0 = off
    logic       slow;   // 1 = slow tick source
    logic       win;    // window request (bus source only)
  } wd_cfg_t;

  localparam wd_cfg_t CFG_RESET = '{tsel: 2'b11, slow: 1'b1, win: 1'b0};

  function automatic int wd_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdog_optregs.sv
module wdog_optregs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output wd_cfg_t    cfg,
  output logic       tmo_lock,
  output logic       src_lock,
  output logic       reload
);

  logic tmo_hit, src_hit;
  logic unused_hi;

  assign tmo_hit   = wr_en && (wr_addr == A_TMO) && !tmo_lock;
  assign src_hit   = wr_en && (wr_addr == A_SRC) && !src_lock;
  assign reload    = tmo_hit || src_hit;
  assign unused_hi = ^wr_data[7:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= CFG_RESET;
      tmo_lock <= 1'b0;
      src_lock <= 1'b0;
    end else begin
      if (tmo_hit) begin
        cfg.tsel <= wr_data[1:0];
        tmo_lock <= 1'b1;
      end
      if (src_hit) begin
        cfg.slow <= wr_data[0];
        cfg.win  <= wr_data[1];
        src_lock <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BUS_SH0 = 13,
  parameter int BUS_SH1 = 16,
  parameter int BUS_SH2 = 18,
  parameter int LP_SH0  = 5,
  parameter int LP_SH1  = 8,
  parameter int LP_SH2  = 10,
  parameter int CNT_W   = 18
)(
  input  logic             clk,
  input  logic             rst,
  input  wd_cfg_t          cfg,
  input  logic             clear,
  input  logic             halt,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt,
  output logic             enabled,
  output logic             expire,
  output logic             early
);

  localparam int LIM_W = CNT_W + 1;

  int               sh;
  logic [LIM_W-1:0] lim;
  logic [LIM_W-1:0] win_start;
  logic [LIM_W-1:0] last;
  logic             adv;
  logic             win_act;

  // limit table: source bit picks the set, select picks the entry
  always_comb begin
    case ({cfg.slow, cfg.tsel})
      3'b0_01: sh = BUS_SH0;
      3'b0_10: sh = BUS_SH1;
      3'b0_11: sh = BUS_SH2;
      3'b1_01: sh = LP_SH0;
      3'b1_10: sh = LP_SH1;
      3'b1_11: sh = LP_SH2;
      default: sh = 0;
    endcase
  end

  assign lim       = LIM_W'(1) << sh;
  assign last      = lim - LIM_W'(1);
  assign win_start = lim - (lim >> 2);
  assign enabled   = (cfg.tsel != 2'b00);
  assign win_act   = cfg.win && !cfg.slow;
  assign adv       = enabled && !halt && (cfg.slow ? tick_en : 1'b1);
  assign expire    = adv && ({1'b0, cnt} == last);
  assign early     = win_act && ({1'b0, cnt} < win_start);

  always_ff @(posedge clk) begin
    if (rst || clear || (cfg.slow && halt) || expire)
      cnt <= '0;
    else if (adv)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdog_keychk.sv
module wdog_keychk
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enabled,
  input  logic       svc_wr,
  input  logic [7:0] data,
  input  logic       early,
  input  logic       abort,
  output logic       restart,
  output logic       bad
);

  logic armed;
  logic take;
  logic is_arm, is_fire;

  assign take    = enabled && svc_wr;
  assign is_arm  = (data == KEY_ARM);
  assign is_fire = (data == KEY_FIRE);
  assign bad     = take && (early || !(is_arm || is_fire));
  assign restart = take && !bad && is_fire && armed;

  always_ff @(posedge clk) begin
    if (rst || bad || restart || abort)
      armed <= 1'b0;
    else if (take && is_arm)
      armed <= 1'b1;
  end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int BUS_SH0 = 13,
  parameter int BUS_SH1 = 16,
  parameter int BUS_SH2 = 18,
  parameter int LP_SH0  = 5,
  parameter int LP_SH1  = 8,
  parameter int LP_SH2  = 10
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       por,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       tick_en,
  input  logic       dbg_mode,
  input  logic       stop_mode,
  output logic       rst_req,
  output logic       cause_timeout,
  output logic       cause_badkey
);

  localparam int CNT_W = wd_max(wd_max(wd_max(BUS_SH0, BUS_SH1), wd_max(BUS_SH2, LP_SH0)),
                                wd_max(LP_SH1, LP_SH2));

  logic             any_rst;
  wd_cfg_t          cfg;
  logic             tmo_lock, src_lock, reload;
  logic [CNT_W-1:0] cnt;
  logic             enabled, expire, early;
  logic             restart, bad, fire, halt, svc_wr;

  assign any_rst = rst || por;
  assign halt    = dbg_mode || stop_mode;
  assign svc_wr  = wr_en && (wr_addr == A_SVC);
  assign fire    = expire || bad;

  wdog_optregs u_opt (
    .clk(clk), .rst(any_rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .tmo_lock(tmo_lock), .src_lock(src_lock), .reload(reload)
  );

  wdog_counter #(
    .BUS_SH0(BUS_SH0), .BUS_SH1(BUS_SH1), .BUS_SH2(BUS_SH2),
    .LP_SH0(LP_SH0), .LP_SH1(LP_SH1), .LP_SH2(LP_SH2), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(any_rst), .cfg(cfg), .clear(reload || restart || fire),
    .halt(halt), .tick_en(tick_en), .cnt(cnt), .enabled(enabled),
    .expire(expire), .early(early)
  );

  wdog_keychk u_key (
    .clk(clk), .rst(any_rst), .enabled(enabled), .svc_wr(svc_wr), .data(wr_data),
    .early(early), .abort(fire || reload), .restart(restart), .bad(bad)
  );

  always_ff @(posedge clk) begin
    if (any_rst) rst_req <= 1'b0;
    else         rst_req <= fire;
  end

  // cause flags survive rst; only por clears them
  always_ff @(posedge clk) begin
    if (por) begin
      cause_timeout <= 1'b0;
      cause_badkey  <= 1'b0;
    end else if (!rst && fire) begin
      cause_timeout <= expire && !bad;
      cause_badkey  <= bad;
    end
  end

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 18
)(
  input logic             clk,
  input logic             rst,
  input logic             por,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             dbg_mode,
  input logic             stop_mode,
  input logic             rst_req,
  input logic             cause_timeout,
  input logic             cause_badkey,
  input wd_cfg_t          cfg,
  input logic             tmo_lock,
  input logic             src_lock,
  input logic [CNT_W-1:0] cnt,
  input logic             enabled
);

  AST_BADKEY_RESET: assert property (@(posedge clk) disable iff (rst || por)
    (enabled && wr_en && wr_addr == A_SVC && wr_data != KEY_ARM && wr_data != KEY_FIRE)
      |=> (rst_req && cause_badkey)); // R3

  AST_FLAG_CHANGE_ON_REQ: assert property (@(posedge clk) disable iff (rst || por)
    ($fell(cause_timeout) || $fell(cause_badkey)) |-> rst_req); // R11

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst || por)
    rst_req |-> (cause_timeout || cause_badkey)); // R2

  AST_TMO_LOCKED: assert property (@(posedge clk) disable iff (rst || por)
    (tmo_lock && wr_en && wr_addr == A_TMO) |=> $stable(cfg.tsel)); // R8

  AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (rst || por)
    (src_lock && wr_en && wr_addr == A_SRC) |=> ($stable(cfg.slow) && $stable(cfg.win))); // R8

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst || por)
    (!cfg.slow && (dbg_mode || stop_mode) && !wr_en) |=> $stable(cnt)); // R9

  AST_SLOW_CLEAR: assert property (@(posedge clk) disable iff (rst || por)
    (cfg.slow && (dbg_mode || stop_mode)) |=> (cnt == '0)); // R9

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst || por)
    !enabled |=> !rst_req); // R12

endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_wdog_keyed.sv
module sim_wdog_keyed;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       por = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick_en = 1'b1;
  logic       dbg_mode = 1'b0;
  logic       stop_mode = 1'b0;
  logic       rst_req, cause_timeout, cause_badkey;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // limits: bus 16/32/64, slow 8/16/32
  wdog_keyed #(
    .BUS_SH0(4), .BUS_SH1(5), .BUS_SH2(6),
    .LP_SH0(3), .LP_SH1(4), .LP_SH2(5)
  ) u0 (
    .clk(clk), .rst(rst), .por(por), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_en(tick_en), .dbg_mode(dbg_mode),
    .stop_mode(stop_mode), .rst_req(rst_req), .cause_timeout(cause_timeout),
    .cause_badkey(cause_badkey)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic do_por();
    por = 1'b1;
    idle(2);
    por = 1'b0;
  endtask

  task automatic do_rst();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  // rst_req must be low for n-1 falling edges, high at the n-th, low after
  task automatic expect_fire(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
    @(negedge clk);
    chk(rst_req == 1'b1, req, rst_req, 1);
    chk(cause_timeout == 1'b1 && cause_badkey == 1'b0, req,
        {cause_timeout, cause_badkey}, 2);
    @(negedge clk);
    chk(rst_req == 1'b0, {req, " pulse width"}, rst_req, 0);
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic t_defaults_and_flags();
    do_por();
    chk(rst_req == 1'b0 && cause_timeout == 1'b0 && cause_badkey == 1'b0, "R1 reset state",
        {rst_req, cause_timeout, cause_badkey}, 0);
    expect_fire(32, "R1 default slow longest");
    do_rst();
    chk(cause_timeout == 1'b1, "R11 flag kept over rst", cause_timeout, 1);
    wr(A_SVC_T, 8'h55);
    chk(rst_req == 1'b0 && cause_timeout == 1'b1 && cause_badkey == 1'b0,
        "R11 service write leaves flags", {rst_req, cause_timeout, cause_badkey}, 2);
    do_por();
    chk(cause_timeout == 1'b0, "R11 por clears flag", cause_timeout, 0);
  endtask

  localparam logic [1:0] A_SVC_T = 2'd0;
  localparam logic [1:0] A_TMO_T = 2'd1;
  localparam logic [1:0] A_SRC_T = 2'd2;

  task automatic t_badkey();
    do_por();
    wr(A_SVC_T, 8'h12);
    chk(rst_req == 1'b1, "R3 bad byte request", rst_req, 1);
    chk(cause_badkey == 1'b1 && cause_timeout == 1'b0, "R3 cause",
        {cause_timeout, cause_badkey}, 1);
    @(negedge clk);
    chk(rst_req == 1'b0, "R2 pulse width after bad byte", rst_req, 0);
  endtask

  task automatic t_key_seq();
    do_por();
    wr(A_TMO_T, 8'h01);
    wr(A_SRC_T, 8'h00);            // bus, limit 16, restart
    idle(3);
    wr(A_SVC_T, 8'h55);
    wr(A_SVC_T, 8'hAA);            // restart
    idle(5);
    wr(A_SVC_T, 8'hAA);            // no 0x55 pending: ignored
    expect_fire(10, "R4 lone AA ignored");
    wr(A_SVC_T, 8'h55);
    wr(A_SVC_T, 8'h55);
    wr(A_SVC_T, 8'hAA);            // restart
    expect_fire(16, "R4 repeated 55 then AA restarts");
  endtask

  task automatic t_select();
    do_por();
    wr(A_TMO_T, 8'h02);
    wr(A_SRC_T, 8'h00);
    expect_fire(32, "R5 bus mid limit");
    do_por();
    wr(A_TMO_T, 8'h01);
    wr(A_SRC_T, 8'h01);
    expect_fire(8, "R5 slow short limit");
  endtask

  task automatic t_window();
    do_por();
    wr(A_TMO_T, 8'h01);
    wr(A_SRC_T, 8'h02);            // bus, window, limit 16
    idle(11);
    wr(A_SVC_T, 8'h55);            // sampled at count 11: early
    chk(rst_req == 1'b1 && cause_badkey == 1'b1, "R6 early write",
        {rst_req, cause_badkey}, 3);
    do_por();
    wr(A_TMO_T, 8'h01);
    wr(A_SRC_T, 8'h02);
    idle(12);
    wr(A_SVC_T, 8'h55);            // count 12: inside window
    wr(A_SVC_T, 8'hAA);
    chk(rst_req == 1'b0, "R6 window write accepted", rst_req, 0);
    expect_fire(16, "R6 restart in window");
  endtask

  task automatic t_window_slow();
    do_por();
    wr(A_TMO_T, 8'h01);
    wr(A_SRC_T, 8'h03);            // slow, window bit ignored, limit 8
    idle(1);
    wr(A_SVC_T, 8'h55);
    wr(A_SVC_T, 8'hAA);
    chk(rst_req == 1'b0, "R7 early write allowed on slow", rst_req, 0);
    expect_fire(8, "R7 restart on slow");
  endtask

  task automatic t_write_once();
    do_por();
    idle(20);
    wr(A_TMO_T, 8'h01);            // first write: slow limit 8, restart
    expect_fire(8, "R8 first write restarts");
    wr(A_SRC_T, 8'h00);            // bus limit 16, restart
    idle(5);
    wr(A_TMO_T, 8'h03);            // ignored
    expect_fire(10, "R8 later write ignored");
  endtask

  task automatic t_lowpower();
    do_por();
    wr(A_TMO_T, 8'h01);
    wr(A_SRC_T, 8'h00);            // bus 16
    idle(4);
    dbg_mode = 1'b1;
    idle(20);
    dbg_mode = 1'b0;
    expect_fire(12, "R9 bus hold");
    do_por();
    wr(A_TMO_T, 8'h01);
    wr(A_SRC_T, 8'h01);            // slow 8
    idle(5);
    stop_mode = 1'b1;
    idle(3);
    stop_mode = 1'b0;
    expect_fire(8, "R9 slow clear");
  endtask

  task automatic t_tick();
    tick_en = 1'b0;
    do_por();
    expect_quiet(100, "R10 no tick no count");
    tick_en = 1'b1;
    expect_fire(32, "R10 counts on tick");
  endtask

  task automatic t_off();
    do_por();
    wr(A_TMO_T, 8'h00);
    expect_quiet(200, "R12 off no expiry");
    wr(A_SVC_T, 8'h12);
    chk(rst_req == 1'b0 && cause_badkey == 1'b0, "R12 service ignored when off",
        {rst_req, cause_badkey}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_defaults_and_flags();
    t_badkey();
    t_key_seq();
    t_select();
    t_window();
    t_window_slow();
    t_write_once();
    t_lowpower();
    t_tick();
    t_off();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

endmodule